// File: doc/BRIEF.md
# Nonvolatile Memory Control Register

This block is the byte-wide control and status register that software uses to drive an on-chip nonvolatile memory controller. One register holds a region selector, an erase-enable bit, a write-enable bit, a sticky write-error flag, and two start bits: one for writes and one for reads. When software sets a start bit, the block sends a one-cycle strobe to the memory-operation sequencer, together with the operation's region and erase qualifier. When the sequencer reports completion, the block clears that start bit itself.

Writes are protected by a key sequence. Software writes 0x55 and then 0xAA to a separate key register on two consecutive bus accesses. A write-start request is honoured only on the bus access that comes right after that pair. Any start attempt that passes the key check but names an invalid, protected or out-of-region address is refused and raises the error flag. A warm reset that cuts a write short also raises the flag.

Top module: `nvm_ctrl_reg`

## Requirements
- R1: After a cold reset (`por_n` low), the control register reads 0x00 and no strobe is active. Bit 5 always reads 0.
- R2: A control write (`bus_sel`=0) stores region in bits 7:6, erase enable in bit 4 and write enable in bit 2. These fields read back from the same positions, and bit 5 reads 0.
- R3: A control write with bit 1 set starts a write only if the two bus accesses just before it were key writes (`bus_sel`=1) of 0x55 and then 0xAA. Any other access in between, including a read, cancels the key. Idle cycles do not cancel it. Without the key, the write of 1 to bit 1 is ignored.
- R4: A keyed write start with bit 2 of the written byte equal to 0 issues no strobe and leaves bit 1 at 0.
- R5: A keyed write start sets the error flag (bit 3) and issues no strobe if any of these hold: `adr_valid` is 0, `adr_prot` is 1, or the region class of the written bits 7:6 differs from the class of `adr_region`. The classes are: bit 0 set means ID/configuration, otherwise 10 means program flash, otherwise data EEPROM.
- R6: An accepted write start sets bit 1 and pulses `wr_start` for exactly one cycle. It presents `op_region` as the written region, and presents `op_erase` = 1 only when erase enable is set and the region is 10.
- R7: While a write is in progress, writing 0 to bit 1 has no effect. Bit 1 clears only on the cycle after `wr_done`.
- R8: A control write with bit 0 set, when no operation is in progress, sets bit 0 and pulses `rd_start` for one cycle with `op_erase`=0. It needs no key. Bit 0 clears after `rd_done`, and writing 0 to it has no effect.
- R9: Hardware never clears the error flag. A control write replaces it with bit 3 of the written byte, so software can both clear it and set it.
- R10: A warm reset (`warm_n` low) clears every field except the error flag. It sets the error flag if a write was in progress, and otherwise keeps the flag's old value.
- R11: Only one operation runs at a time. A start request of either kind is ignored while a write or a read is in progress. If both start bits are written at once and the write is accepted, the read request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, active low, synchronous |
| warm_n | input | 1 | Warm reset, active low, synchronous |
| bus_sel | input | 1 | Register select: 0 control, 1 key |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data; the key register reads 0 |
| adr_region | input | 2 | Region the current address belongs to |
| adr_valid | input | 1 | Current address exists |
| adr_prot | input | 1 | Current address is write protected |
| wr_done | input | 1 | Sequencer finished the write |
| rd_done | input | 1 | Sequencer loaded the read data |
| wr_start | output | 1 | One-cycle write launch |
| rd_start | output | 1 | One-cycle read launch |
| op_erase | output | 1 | Launched write is an erase |
| op_region | output | 2 | Region of the launched operation |

## Verification
The hardest states to reach are the ones where a start request arrives just as the key has been armed and the sequencer is busy, or where a warm reset lands in the middle of a write. Random stimulus rarely produces either. The directed phase builds them on purpose: it launches a read with a long latency and then arms the key during it, it breaks a key with a read access, and it pulses warm reset during a write. The random phase biases most operations toward complete key sequences followed by start requests. Its address flags are usually good, and a running reference model is compared on every cycle.

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg #(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] adr_region,
  input  logic       adr_valid,
  input  logic       adr_prot,
  input  logic       wr_done,
  input  logic       rd_done,
  output logic       wr_start,
  output logic       rd_start,
  output logic       op_erase,
  output logic [1:0] op_region
);

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_ARMED} key_t;

  key_t       key_q;
  logic [1:0] region_q;
  logic       erase_q, err_q, wren_q, wr_q, rd_q;

  function automatic logic [1:0] region_class(input logic [1:0] r);
    return r[0] ? 2'd2 : (r[1] ? 2'd1 : 2'd0);
  endfunction

  wire ctl_wr  = bus_we && !bus_sel;
  wire key_wr  = bus_we && bus_sel;
  wire busy    = wr_q || rd_q;
  wire wr_try  = ctl_wr && bus_wdata[1] && (key_q == KEY_ARMED) && !busy;
  wire adr_bad = !adr_valid || adr_prot ||
                 (region_class(bus_wdata[7:6]) != region_class(adr_region));
  wire wr_go   = wr_try && !adr_bad && bus_wdata[2];
  wire rd_go   = ctl_wr && bus_wdata[0] && !busy && !wr_go;

  assign bus_rdata = bus_sel ? 8'h00 : {region_q, 1'b0, erase_q, err_q, wren_q, wr_q, rd_q};

  always_ff @(posedge clk) begin
    if (!por_n) begin
      key_q     <= KEY_IDLE;
      region_q  <= '0;
      erase_q   <= 1'b0;
      err_q     <= 1'b0;
      wren_q    <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_start  <= 1'b0;
      rd_start  <= 1'b0;
      op_erase  <= 1'b0;
      op_region <= '0;
    end else if (!warm_n) begin
      key_q     <= KEY_IDLE;
      region_q  <= '0;
      erase_q   <= 1'b0;
      err_q     <= err_q | wr_q;
      wren_q    <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_start  <= 1'b0;
      rd_start  <= 1'b0;
      op_erase  <= 1'b0;
      op_region <= '0;
    end else begin
      wr_start <= wr_go;
      rd_start <= rd_go;
      if (ctl_wr) begin
        region_q <= bus_wdata[7:6];
        erase_q  <= bus_wdata[4];
        wren_q   <= bus_wdata[2];
      end
      if (wr_try && adr_bad) err_q <= 1'b1;
      else if (ctl_wr)       err_q <= bus_wdata[3];
      if (wr_go) begin
        wr_q      <= 1'b1;
        op_erase  <= bus_wdata[4] && (bus_wdata[7:6] == 2'b10);
        op_region <= bus_wdata[7:6];
      end else if (wr_done) begin
        wr_q <= 1'b0;
      end
      if (rd_go) begin
        rd_q      <= 1'b1;
        op_erase  <= 1'b0;
        op_region <= bus_wdata[7:6];
      end else if (rd_done) begin
        rd_q <= 1'b0;
      end
      if (bus_we || bus_re) begin
        if (key_wr && bus_wdata == KEY_A)                       key_q <= KEY_HALF;
        else if (key_wr && bus_wdata == KEY_B && key_q == KEY_HALF) key_q <= KEY_ARMED;
        else                                                    key_q <= KEY_IDLE;
      end
    end
  end

  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    wr_start |=> !wr_start);
  a_r6_wr_bit_with_strobe: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    wr_start |-> wr_q);
  a_r7_wr_held: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (wr_q && !wr_done) |=> wr_q);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (err_q && !ctl_wr) |=> err_q);
  a_r11_one_op: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    !(wr_q && rd_q));
  a_r3_needs_key: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (ctl_wr && key_q != KEY_ARMED) |=> !wr_start);

endmodule

// File: tb/nvm_ctrl_reg_bench.sv
module nvm_ctrl_reg_bench;
  localparam int WR_LAT = 5;
  localparam int RD_LAT = 6;

  logic clk = 0, por_n = 0, warm_n = 1;
  logic bus_sel = 0, bus_we = 0, bus_re = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] adr_region = 0;
  logic adr_valid = 1, adr_prot = 0;
  logic wr_done = 0, rd_done = 0;
  logic wr_start, rd_start, op_erase;
  logic [1:0] op_region;
  int checks = 0, errors = 0, wcnt = 0, rcnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nvm_ctrl_reg u_nvm_ctrl_reg (.*);

  // sequencer stand-in
  always @(posedge clk) begin
    if (!por_n || !warm_n) begin
      wcnt <= 0; rcnt <= 0; wr_done <= 0; rd_done <= 0;
    end else begin
      wr_done <= (wcnt == 1);
      rd_done <= (rcnt == 1);
      wcnt <= wr_start ? WR_LAT : (wcnt > 0 ? wcnt - 1 : 0);
      rcnt <= rd_start ? RD_LAT : (rcnt > 0 ? rcnt - 1 : 0);
    end
  end

  function automatic logic [1:0] cls(input logic [1:0] r);
    return r[0] ? 2'd2 : (r[1] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [7:0] pack(input logic [1:0] rg, input logic e, er, we, w, r);
    return {rg, 1'b0, e, er, we, w, r};
  endfunction

  // reference model
  logic [1:0] m_rg, m_or; logic m_e, m_er, m_we, m_w, m_r, m_ws, m_rs, m_oe; int m_ul;
  always @(posedge clk) begin
    logic cw, bsy, tw, bad, gw, gr; logic [7:0] d;
    if (!por_n) begin
      m_rg = 0; m_or = 0; m_e = 0; m_er = 0; m_we = 0; m_w = 0; m_r = 0;
      m_ws = 0; m_rs = 0; m_oe = 0; m_ul = 0;
    end else if (!warm_n) begin
      m_er = m_er | m_w;
      m_rg = 0; m_or = 0; m_e = 0; m_we = 0; m_w = 0; m_r = 0;
      m_ws = 0; m_rs = 0; m_oe = 0; m_ul = 0;
    end else begin
      d = bus_wdata; cw = bus_we && !bus_sel; bsy = m_w || m_r;
      tw = cw && d[1] && m_ul == 2 && !bsy;
      bad = !adr_valid || adr_prot || cls(d[7:6]) != cls(adr_region);
      gw = tw && !bad && d[2];
      gr = cw && d[0] && !bsy && !gw;
      m_ws = gw; m_rs = gr;
      if (m_w && wr_done) m_w = 0;
      if (m_r && rd_done) m_r = 0;
      if (cw) begin m_rg = d[7:6]; m_e = d[4]; m_we = d[2]; m_er = d[3]; end
      if (tw && bad) m_er = 1;
      if (gw) begin m_w = 1; m_oe = d[4] && d[7:6] == 2'b10; m_or = d[7:6]; end
      if (gr) begin m_r = 1; m_oe = 0; m_or = d[7:6]; end
      if (bus_we || bus_re)
        m_ul = (bus_we && bus_sel && d == 8'h55) ? 1 :
               (bus_we && bus_sel && d == 8'hAA && m_ul == 1) ? 2 : 0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (por_n && warm_n && !finished) begin
      if (!bus_sel) begin
        chk("R2 fields", {bus_rdata[7:6], bus_rdata[4], bus_rdata[2]}, {m_rg, m_e, m_we});
        chk("R9 err", bus_rdata[3], m_er);
        chk("R3 wr bit", bus_rdata[1], m_w);
        chk("R8 rd bit", bus_rdata[0], m_r);
        chk("R1 bit5", bus_rdata[5], 1'b0);
      end
      chk("R6 strobes", {wr_start, rd_start}, {m_ws, m_rs});
      chk("R6 op", {op_erase, op_region}, {m_oe, m_or});
    end
  end

  task automatic bw(input logic s, input logic [7:0] d);
    @(negedge clk); bus_sel = s; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_sel = 0;
  endtask
  task automatic br(input logic s);
    @(negedge clk); bus_sel = s; bus_re = 1;
    @(negedge clk); bus_re = 0; bus_sel = 0;
  endtask
  task automatic keyed(input logic [7:0] d);
    bw(1, 8'h55); bw(1, 8'hAA); bw(0, d);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic peek(input string tag, input logic [7:0] exp);
    bus_sel = 0; #1; chk(tag, bus_rdata, exp);
  endtask
  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3); por_n = 1; idle(1);
    peek("R1 cold reset", 8'h00);
    chk("R1 strobes", {wr_start, rd_start}, 2'b00);
    bw(0, 8'hDC); peek("R2 readback no key", 8'hDC);
    bw(0, 8'h00);
    keyed(8'h06); peek("R3 keyed start", 8'h06);
    chk("R6 wr_start", wr_start, 1'b1);
    idle(1); chk("R6 one pulse", wr_start, 1'b0);
    bw(0, 8'h04); peek("R7 zero ignored", 8'h06);
    idle(8); peek("R7 hw clear", 8'h04);
    bw(1, 8'h55); br(1); bw(1, 8'hAA); bw(0, 8'h06);
    peek("R3 broken key", 8'h04);
    bw(1, 8'h55); bw(1, 8'hAA); idle(2); bw(0, 8'h06);
    peek("R3 idle keeps key", 8'h06); idle(8);
    keyed(8'h02); peek("R4 no wren", 8'h00);
    chk("R4 no strobe", wr_start, 1'b0);
    adr_prot = 1; keyed(8'h06); peek("R5 protected", 8'h0C);
    chk("R5 no strobe", wr_start, 1'b0); adr_prot = 0;
    bw(0, 8'h04); peek("R9 sw clear", 8'h04);
    bw(0, 8'h0C); peek("R9 sw set", 8'h0C); bw(0, 8'h00);
    adr_region = 2'b11; keyed(8'h46); peek("R5 id class", 8'h46);
    chk("R6 op_region id", op_region, 2'b01); idle(8);
    adr_region = 2'b00; keyed(8'h86); peek("R5 mismatch", 8'h8C);
    bw(0, 8'h00);
    adr_region = 2'b10; keyed(8'h96); chk("R6 erase pfm", op_erase, 1'b1);
    idle(8); peek("R6 erase done", 8'h94);
    adr_region = 2'b00; keyed(8'h16); chk("R6 erase ee", op_erase, 1'b0);
    idle(8); bw(0, 8'h00);
    bw(0, 8'h01); peek("R8 read start", 8'h01);
    chk("R8 rd_start", rd_start, 1'b1);
    keyed(8'h06); peek("R11 wr blocked", 8'h05);
    chk("R11 no wr strobe", wr_start, 1'b0);
    idle(8); peek("R8 read done", 8'h04);
    keyed(8'h06); idle(1);
    @(negedge clk); warm_n = 0; @(negedge clk); warm_n = 1;
    peek("R10 warm mid write", 8'h08);
    @(negedge clk); warm_n = 0; @(negedge clk); warm_n = 1;
    peek("R10 warm idle keeps err", 8'h08);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    peek("R1 cold clears err", 8'h00);

    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom % 20;
      adr_valid = ($urandom % 8) != 0;
      adr_prot  = ($urandom % 8) == 0;
      adr_region = $urandom;
      if (sel < 9) keyed({$urandom} | 8'h06);
      else if (sel < 12) bw(0, $urandom);
      else if (sel < 14) bw(1, ($urandom % 2) ? 8'h55 : 8'hAA);
      else if (sel < 16) br($urandom);
      else if (sel < 19) idle(1 + $urandom % 4);
      else begin @(negedge clk); warm_n = 0; @(negedge clk); warm_n = 1; end
    end
    idle(10);
    finish_run();
  end
endmodule